// File: doc/BRIEF.md
# Programmable Limited-Range Pixel Clamp

This block sits in a display output path. It restricts every component of a three-component, 12-bit-per-component pixel stream to a legal code range. A 3-bit format code picks the range. Three codes give fixed limited ranges for 8, 10 and 12 bits per component, each scaled to the 12-bit grid. A fourth code takes a separate lower and upper bound for each component from programmable inputs. When the clamp enable is low, or the code is not one of these four, pixels pass through unchanged.

The enable, the format code and the programmable bounds are copied into shadow registers only when the frame-start pulse is high. A configuration change made in the middle of a frame therefore cannot alter pixels until the next frame begins. The frame-start pulse goes with the first pixel of a frame, and that pixel already uses the new settings. The output is registered, so the clamped pixel and its valid appear one clock after the input.

Top module: `pix_range_clamp`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier, and a pixel accepted with `in_valid` high appears on `out_pix` one clock later.
- R2: While `in_valid` is low, `out_pix` keeps its previous value.
- R3: After reset, `out_valid` and `out_pix` are zero and the shadow settings are disabled with format 0, so pixels pass through until a frame-start pulse loads new settings.
- R4: With the captured enable at 0, every component passes through unchanged, whatever the format code.
- R5: With the enable set, codes 1, 2 and 3 clamp every component to the range [16<<4, 235<<4], [64<<2, 940<<2] and [256, 3760] respectively.
- R6: With the enable set, code 7 clamps each component to its own programmable bounds. The bounds are packed like the pixel: R in bits 35:24, G in bits 23:12, B in bits 11:0.
- R7: A value below the lower bound outputs the lower bound, and a value above the upper bound outputs the upper bound. The lower test is applied first, so if the lower bound exceeds the upper bound, any value below the lower bound outputs the lower bound.
- R8: Codes 0, 4, 5 and 6 apply no clamping, even with the enable set.
- R9: Enable, code and programmable bounds are captured only in a cycle with `frame_start` high. They apply to that cycle's pixel and to all later pixels. Changes in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse with the first pixel of a frame; loads the shadow settings |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 36 | Input pixel, R/G/B packed high to low |
| clamp_en | input | 1 | Live clamp enable |
| fmt_code | input | 3 | Live range selection code |
| prog_lo | input | 36 | Live programmable lower bounds, one per component |
| prog_hi | input | 36 | Live programmable upper bounds, one per component |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 36 | Clamped pixel |

## Verification
A stuck or wrongly captured shadow setting shows up at the ports on the first valid pixel after the faulty frame start. It appears as a value outside the expected range, or as a pixel that passes through when it should be clamped. A bound selector or comparator that is off by one shows only when a pixel lands exactly on a bound or next to it, so the stimulus targets those codes directly. Every such fault is visible one clock after the offending input. The reference model compares every cycle, so the first mismatching cycle is the one that reveals the fault.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;

  localparam logic [2:0] FMT_NONE  = 3'd0;
  localparam logic [2:0] FMT_LIM8  = 3'd1;
  localparam logic [2:0] FMT_LIM10 = 3'd2;
  localparam logic [2:0] FMT_LIM12 = 3'd3;
  localparam logic [2:0] FMT_PROG  = 3'd7;

  // true when the code names one of the fixed limited ranges
  function automatic logic is_fixed(input logic [2:0] code);
    return (code == FMT_LIM8) || (code == FMT_LIM10) || (code == FMT_LIM12);
  endfunction

  // true when the code asks for any clamping at all
  function automatic logic is_clamping(input logic [2:0] code);
    return is_fixed(code) || (code == FMT_PROG);
  endfunction

  // fixed lower bound scaled from the nominal depth onto a cw-bit grid
  function automatic int unsigned fixed_lo(input logic [2:0] code, input int unsigned cw);
    case (code)
      FMT_LIM8:  return 32'd16  << (cw - 8);
      FMT_LIM10: return 32'd64  << (cw - 10);
      FMT_LIM12: return 32'd256 << (cw - 12);
      default:   return 32'd0;
    endcase
  endfunction

  // fixed upper bound scaled from the nominal depth onto a cw-bit grid
  function automatic int unsigned fixed_hi(input logic [2:0] code, input int unsigned cw);
    case (code)
      FMT_LIM8:  return 32'd235  << (cw - 8);
      FMT_LIM10: return 32'd940  << (cw - 10);
      FMT_LIM12: return 32'd3760 << (cw - 12);
      default:   return (32'd1 << cw) - 32'd1;
    endcase
  endfunction

endpackage

// File: rtl/pix_clamp_shadow.sv
module pix_clamp_shadow
  import pix_clamp_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 3,
  parameter logic [CW-1:0] DEF_LO = 'h010,
  parameter logic [CW-1:0] DEF_HI = 'hFEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             live_en,
  input  logic [2:0]       live_fmt,
  input  logic [NC*CW-1:0] live_lo,
  input  logic [NC*CW-1:0] live_hi,
  output logic             eff_en,
  output logic [2:0]       eff_fmt,
  output logic [NC*CW-1:0] eff_lo,
  output logic [NC*CW-1:0] eff_hi,
  output logic             sh_en,
  output logic [2:0]       sh_fmt,
  output logic [NC*CW-1:0] sh_lo,
  output logic [NC*CW-1:0] sh_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en  <= 1'b0;
      sh_fmt <= FMT_NONE;
      sh_lo  <= {NC{DEF_LO}};
      sh_hi  <= {NC{DEF_HI}};
    end else if (frame_start) begin
      sh_en  <= live_en;
      sh_fmt <= live_fmt;
      sh_lo  <= live_lo;
      sh_hi  <= live_hi;
    end
  end

  // the pixel that carries frame_start already sees the new settings
  always_comb begin
    eff_en  = frame_start ? live_en  : sh_en;
    eff_fmt = frame_start ? live_fmt : sh_fmt;
    eff_lo  = frame_start ? live_lo  : sh_lo;
    eff_hi  = frame_start ? live_hi  : sh_hi;
  end

endmodule

// File: rtl/pix_clamp_bounds.sv
module pix_clamp_bounds
  import pix_clamp_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 3
) (
  input  logic             en,
  input  logic [2:0]       fmt,
  input  logic [NC*CW-1:0] prog_lo,
  input  logic [NC*CW-1:0] prog_hi,
  output logic             active,
  output logic [NC*CW-1:0] lane_lo,
  output logic [NC*CW-1:0] lane_hi
);

  logic [CW-1:0] fix_lo;
  logic [CW-1:0] fix_hi;
  logic          use_prog;

  assign fix_lo   = CW'(fixed_lo(fmt, CW));
  assign fix_hi   = CW'(fixed_hi(fmt, CW));
  assign use_prog = (fmt == FMT_PROG);
  assign active   = en && is_clamping(fmt);

  for (genvar c = 0; c < NC; c++) begin : g_lane
    assign lane_lo[c*CW +: CW] = use_prog ? prog_lo[c*CW +: CW] : fix_lo;
    assign lane_hi[c*CW +: CW] = use_prog ? prog_hi[c*CW +: CW] : fix_hi;
  end

endmodule

// File: rtl/pix_clamp_lane.sv
module pix_clamp_lane #(
  parameter int unsigned CW = 12
) (
  input  logic          active,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] y
);

  function automatic logic [CW-1:0] limit(input logic [CW-1:0] v,
                                          input logic [CW-1:0] l,
                                          input logic [CW-1:0] h);
    if (v < l)      return l;
    else if (v > h) return h;
    else            return v;
  endfunction

  assign y = active ? limit(x, lo, hi) : x;

endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
  import pix_clamp_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 3,
  parameter logic [CW-1:0] DEF_LO = 'h010,
  parameter logic [CW-1:0] DEF_HI = 'hFEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             in_valid,
  input  logic [NC*CW-1:0] in_pix,
  input  logic             clamp_en,
  input  logic [2:0]       fmt_code,
  input  logic [NC*CW-1:0] prog_lo,
  input  logic [NC*CW-1:0] prog_hi,
  output logic             out_valid,
  output logic [NC*CW-1:0] out_pix
);

  localparam int unsigned PW = NC * CW;

  logic          eff_en;
  logic [2:0]    eff_fmt;
  logic [PW-1:0] eff_plo;
  logic [PW-1:0] eff_phi;
  logic          sh_en;
  logic [2:0]    sh_fmt;
  logic [PW-1:0] sh_lo;
  logic [PW-1:0] sh_hi;
  logic          clamp_active;
  logic [PW-1:0] eff_lo;
  logic [PW-1:0] eff_hi;
  logic [PW-1:0] next_pix;

  pix_clamp_shadow #(.CW(CW), .NC(NC), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_shadow (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .live_en(clamp_en), .live_fmt(fmt_code), .live_lo(prog_lo), .live_hi(prog_hi),
    .eff_en(eff_en), .eff_fmt(eff_fmt), .eff_lo(eff_plo), .eff_hi(eff_phi),
    .sh_en(sh_en), .sh_fmt(sh_fmt), .sh_lo(sh_lo), .sh_hi(sh_hi)
  );

  pix_clamp_bounds #(.CW(CW), .NC(NC)) u_bounds (
    .en(eff_en), .fmt(eff_fmt), .prog_lo(eff_plo), .prog_hi(eff_phi),
    .active(clamp_active), .lane_lo(eff_lo), .lane_hi(eff_hi)
  );

  for (genvar c = 0; c < NC; c++) begin : g_comp
    pix_clamp_lane #(.CW(CW)) u_lane (
      .active(clamp_active),
      .x(in_pix[c*CW +: CW]),
      .lo(eff_lo[c*CW +: CW]),
      .hi(eff_hi[c*CW +: CW]),
      .y(next_pix[c*CW +: CW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= next_pix;
    end
  end

endmodule

// File: rtl/pix_clamp_chk.sv
module pix_clamp_chk #(
  parameter int unsigned CW = 12,
  parameter int unsigned NC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             in_valid,
  input logic [NC*CW-1:0] in_pix,
  input logic             clamp_en,
  input logic [2:0]       fmt_code,
  input logic             out_valid,
  input logic [NC*CW-1:0] out_pix,
  input logic             clamp_active,
  input logic [NC*CW-1:0] eff_lo,
  input logic [NC*CW-1:0] eff_hi,
  input logic             sh_en,
  input logic [2:0]       sh_fmt,
  input logic [NC*CW-1:0] sh_lo,
  input logic [NC*CW-1:0] sh_hi
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));

  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clamp_active) |=> (out_pix == $past(in_pix)));

  for (genvar c = 0; c < NC; c++) begin : g_rng
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && clamp_active && (eff_lo[c*CW +: CW] <= eff_hi[c*CW +: CW])) |=>
      ((out_pix[c*CW +: CW] >= $past(eff_lo[c*CW +: CW])) &&
       (out_pix[c*CW +: CW] <= $past(eff_hi[c*CW +: CW]))));
  end

  a_r9_shadow_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(sh_en) && $stable(sh_fmt) && $stable(sh_lo) && $stable(sh_hi)));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ((sh_en == $past(clamp_en)) && (sh_fmt == $past(fmt_code))));

endmodule

bind pix_range_clamp pix_clamp_chk #(.CW(CW), .NC(NC)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_pix(in_pix), .clamp_en(clamp_en), .fmt_code(fmt_code),
  .out_valid(out_valid), .out_pix(out_pix), .clamp_active(clamp_active),
  .eff_lo(eff_lo), .eff_hi(eff_hi), .sh_en(sh_en), .sh_fmt(sh_fmt),
  .sh_lo(sh_lo), .sh_hi(sh_hi)
);

// File: tb/sim_pix_range_clamp.sv
`timescale 1ns/1ps
module sim_pix_range_clamp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_pix = '0;
  logic        clamp_en = 1'b0;
  logic [2:0]  fmt_code = 3'd0;
  logic [35:0] prog_lo = '0;
  logic [35:0] prog_hi = '0;
  logic        out_valid;
  logic [35:0] out_pix;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench reference state: captured settings and expected output
  int m_en = 0, m_fmt = 0;
  int m_lo[3], m_hi[3];
  int x_valid = 0;
  int x_pix[3] = '{0, 0, 0};

  always #2.5 clk = ~clk;

  pix_range_clamp u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_pix(in_pix), .clamp_en(clamp_en), .fmt_code(fmt_code),
    .prog_lo(prog_lo), .prog_hi(prog_hi), .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int ref_clamp(int x, int en, int fmt, int lo, int hi);
    int l, h;
    if (en == 0) return x;
    case (fmt)
      1: begin l = 16 * 16; h = 235 * 16; end
      2: begin l = 64 * 4;  h = 940 * 4;  end
      3: begin l = 256;     h = 3760;     end
      7: begin l = lo;      h = hi;       end
      default: return x;
    endcase
    if (x < l) return l;
    if (x > h) return h;
    return x;
  endfunction

  // component index 0 = R (bits 35:24), 1 = G, 2 = B (bits 11:0)
  function automatic int field(logic [35:0] v, int k);
    return int'(v[(2-k)*12 +: 12]);
  endfunction

  task automatic set_prog(int rl, int gl, int bl, int rh, int gh, int bh);
    prog_lo = {12'(rl), 12'(gl), 12'(bl)};
    prog_hi = {12'(rh), 12'(gh), 12'(bh)};
  endtask

  task automatic cyc(bit fs, bit v, int r, int g, int b, bit en, int fmt, string tag);
    int e_en, e_fmt;
    @(negedge clk);
    frame_start = fs; in_valid = v; clamp_en = en; fmt_code = 3'(fmt);
    in_pix = {12'(r), 12'(g), 12'(b)};
    @(posedge clk);
    e_en  = fs ? int'(en) : m_en;
    e_fmt = fs ? fmt : m_fmt;
    if (v) begin
      x_pix[0] = ref_clamp(r, e_en, e_fmt, fs ? field(prog_lo, 0) : m_lo[0], fs ? field(prog_hi, 0) : m_hi[0]);
      x_pix[1] = ref_clamp(g, e_en, e_fmt, fs ? field(prog_lo, 1) : m_lo[1], fs ? field(prog_hi, 1) : m_hi[1]);
      x_pix[2] = ref_clamp(b, e_en, e_fmt, fs ? field(prog_lo, 2) : m_lo[2], fs ? field(prog_hi, 2) : m_hi[2]);
    end
    x_valid = int'(v);
    if (fs) begin
      m_en = int'(en); m_fmt = fmt;
      for (int k = 0; k < 3; k++) begin
        m_lo[k] = field(prog_lo, k); m_hi[k] = field(prog_hi, k);
      end
    end
    #1;
    n_vec++;
    if (int'(out_valid) != x_valid || field(out_pix, 0) != x_pix[0] ||
        field(out_pix, 1) != x_pix[1] || field(out_pix, 2) != x_pix[2]) begin
      n_bad++;
      $display("FAIL %s (R1 timing): valid=%0d pix=%0d/%0d/%0d expected valid=%0d pix=%0d/%0d/%0d",
               tag, out_valid, field(out_pix, 0), field(out_pix, 1), field(out_pix, 2),
               x_valid, x_pix[0], x_pix[1], x_pix[2]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin m_lo[k] = 'h010; m_hi[k] = 'hFEF; end
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (out_valid !== 1'b0 || out_pix !== '0) begin
      n_bad++;
      $display("FAIL R3 reset: valid=%0d pix=%h expected valid=0 pix=0", out_valid, out_pix);
    end
    @(negedge clk); rst_n = 1'b1;

    // R3: no frame start yet, live settings must not act
    set_prog('h010, 'h010, 'h010, 'hFEF, 'hFEF, 'hFEF);
    cyc(0, 1, 0, 4095, 100, 1, 1, "R3");
    cyc(0, 1, 4000, 5, 3000, 1, 1, "R3");

    // R4: captured enable low
    cyc(1, 1, 0, 4095, 17, 0, 1, "R4");
    cyc(0, 1, 4095, 0, 4000, 1, 7, "R4");

    // R5: fixed ranges, boundary values
    cyc(1, 1, 255, 256, 257, 1, 1, "R5");
    cyc(0, 1, 3759, 3760, 3761, 1, 1, "R5");
    cyc(1, 1, 0, 4095, 1000, 1, 2, "R5");
    cyc(0, 1, 255, 3761, 256, 1, 2, "R5");
    cyc(1, 1, 0, 4095, 3760, 1, 3, "R5");

    // R8: unused codes pass through
    cyc(1, 1, 0, 4095, 5, 1, 4, "R8");
    cyc(1, 1, 0, 4095, 5, 1, 5, "R8");
    cyc(1, 1, 4095, 0, 9, 1, 6, "R8");
    cyc(1, 1, 4095, 0, 9, 1, 0, "R8");

    // R6: per-component programmable bounds
    set_prog(100, 'h010, 2000, 200, 'hFEF, 3000);
    cyc(1, 1, 50, 0, 1999, 1, 7, "R6");
    cyc(0, 1, 250, 4095, 3001, 1, 7, "R6");
    cyc(0, 1, 150, 2000, 2500, 1, 7, "R6");

    // R7: lower bound above upper bound, lower test wins
    set_prog(3000, 3000, 3000, 1000, 1000, 1000);
    cyc(1, 1, 2000, 500, 3500, 1, 7, "R7");

    // R2: idle cycles keep the last output
    cyc(0, 0, 1, 2, 3, 1, 7, "R2");
    cyc(0, 0, 4095, 4095, 4095, 0, 0, "R2");

    // R9: mid-frame changes ignored until frame start
    set_prog(500, 500, 500, 600, 600, 600);
    cyc(0, 1, 0, 3500, 4095, 0, 1, "R9");
    cyc(1, 1, 0, 3500, 4095, 1, 7, "R9");
    set_prog(0, 0, 0, 4095, 4095, 4095);
    cyc(0, 1, 0, 3500, 4095, 1, 3, "R9");

    // mixed traffic against the model
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      int f;
      f = (($urandom % 4) == 0) ? 7 : int'($urandom % 8);
      if (($urandom % 16) == 0)
        set_prog($urandom % 4096, $urandom % 4096, $urandom % 4096,
                 $urandom % 4096, $urandom % 4096, $urandom % 4096);
      cyc(($urandom % 8) == 0, ($urandom % 4) != 0, $urandom % 4096, $urandom % 4096,
          $urandom % 4096, ($urandom % 4) != 0, f, "R5 R6 R9 mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule